// File: doc/BRIEF.md
# Interrupt Source Conditioner

This block gathers seven interrupt sources into one status vector and conditions each according to its kind. A media-change pin is filtered at a slow sample rate, edge-detected, latched, and sent to a dedicated fast-interrupt output. Three external pins are pure level sources with mixed polarity. A sound FIFO threshold request and a group of timer-underflow events are latched until software acknowledges them through per-source end-of-interrupt strobes.

A mask register gates the status bits onto the outputs. The normal interrupt output is the OR of every enabled source except media change. The fast-interrupt output follows the enabled media-change bit. All outputs come from registers. The timers, the FIFO and any boot-time use of the media pin belong to other blocks.

Status bit positions: 0 media change, 1 sound, 2 external 1, 3 external 2, 4 external 3, 5 and up one per timer (timer i at bit 5+i).

Top module: `irq_cond_top`

## Requirements
- R1: A high media pin takes effect only after DG_SAMPLES (default 2) consecutive samples taken on cycles with `tick_16k` high. A high level seen at a single sample, followed by a low sample, never sets status bit 0.
- R2: Status bit 0 sets one cycle after the filtered media signal rises. It then stays set until `eoi_media` is pulsed. After the strobe it stays clear while the pin remains high.
- R3: `fiq` equals status bit 0 AND mask bit 0, delayed by one cycle. Media change never drives `irq`.
- R4: Status bits 2 and 3 are set one cycle after `ext1_n` or `ext2_n` is low, and clear one cycle after the pin is high again. No strobe affects them.
- R5: Status bit 4 is set one cycle after `ext3` is high and clears one cycle after it is low.
- R6: After a `tmr_uf[i]` pulse, status bit 5+i sets one cycle after the next cycle with `tmr_fall[i]` high. An underflow alone does not set it, and a fall enable with no pending underflow does not set it.
- R7: A pulse on `eoi_tmr[i]` clears status bit 5+i.
- R8: A high `snd_req` sets status bit 1 on the next cycle. `eoi_snd` clears it.
- R9: When a set event and the matching EOI strobe occur in the same cycle, the status bit ends up set.
- R10: When `mask_we` is high, `mask_in` loads the mask. `irq` is the OR of status bits 1 and up, each ANDed with its mask bit, delayed by one cycle.
- R11: Synchronous reset clears the status vector, the mask, `irq` and `fiq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16k | input | 1 | Sample enable for the media filter |
| media_pin | input | 1 | Media-change input, active high |
| snd_req | input | 1 | Sound FIFO threshold request |
| ext1_n | input | 1 | External source 1, active low |
| ext2_n | input | 1 | External source 2, active low |
| ext3 | input | 1 | External source 3, active high |
| tmr_uf | input | N_TMR | Timer underflow pulses |
| tmr_fall | input | N_TMR | Timer clock falling-edge enables |
| eoi_media | input | 1 | Clear strobe for media change |
| eoi_snd | input | 1 | Clear strobe for sound |
| eoi_tmr | input | N_TMR | Clear strobes for the timers |
| mask_we | input | 1 | Mask write enable |
| mask_in | input | NSRC | New mask value |
| status | output | NSRC | Unmasked source status |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The hardest situation to reach is a media pin that is high at one sample and low at the next, which must leave the latch untouched. The stimulus asserts the pin across exactly one `tick_16k` pulse and drops it before the next one. It then gives a clean two-sample assertion followed by an EOI while the pin is still high, and confirms that the filtered level raises no second edge. Same-cycle set and EOI collisions are driven on the sound source, where both inputs are plain ports.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int IDX_MEDIA = 0;
  localparam int IDX_SND   = 1;
  localparam int IDX_EXT1  = 2;
  localparam int IDX_EXT2  = 3;
  localparam int IDX_EXT3  = 4;
  localparam int IDX_TMR0  = 5;
endpackage

// File: rtl/irq_deglitch.sv
module irq_deglitch #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  output logic rise
);
  localparam int HW = SAMPLES - 1;

  logic [HW-1:0]      hist;
  logic               filt;
  logic               filt_d;
  logic [SAMPLES-1:0] win;

  assign win  = {hist, pin};
  assign rise = filt & ~filt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      filt   <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      filt_d <= filt;
      if (tick) begin
        hist <= win[HW-1:0];
        if (&win)       filt <= 1'b1;
        else if (~|win) filt <= 1'b0;
      end
    end
  end

  AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> $past(tick)); // R1
  AST_FILT_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
    $rose(filt) |-> $past(pin)); // R1
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(set) && !$past(rst) |-> q); // R9
  AST_HOLD_UNTIL_EOI: assert property (@(posedge clk) disable iff (rst)
    $past(q) && !$past(clr) && !$past(rst) |-> q); // R2
endmodule

// File: rtl/irq_tmr_sync.sv
module irq_tmr_sync (
  input  logic clk,
  input  logic rst,
  input  logic uf,
  input  logic fall,
  output logic set_ev
);
  logic pend;

  assign set_ev = fall & pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= uf | (pend & ~fall);
  end

  AST_PEND_FROM_UF: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(uf)); // R6
endmodule

// File: rtl/irq_cond_top.sv
module irq_cond_top
  import irq_cond_pkg::*;
#(
  parameter int DG_SAMPLES = 2,
  parameter int N_TMR      = 2,
  localparam int NSRC      = IDX_TMR0 + N_TMR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_16k,
  input  logic             media_pin,
  input  logic             snd_req,
  input  logic             ext1_n,
  input  logic             ext2_n,
  input  logic             ext3,
  input  logic [N_TMR-1:0] tmr_uf,
  input  logic [N_TMR-1:0] tmr_fall,
  input  logic             eoi_media,
  input  logic             eoi_snd,
  input  logic [N_TMR-1:0] eoi_tmr,
  input  logic             mask_we,
  input  logic [NSRC-1:0]  mask_in,
  output logic [NSRC-1:0]  status,
  output logic             irq,
  output logic             fiq
);
  logic            media_rise;
  logic [NSRC-1:0] mask;
  logic [2:0]      lvl;

  irq_deglitch #(.SAMPLES(DG_SAMPLES)) u_dg (
    .clk(clk), .rst(rst), .tick(tick_16k), .pin(media_pin), .rise(media_rise)
  );

  irq_latch u_media (
    .clk(clk), .rst(rst), .set(media_rise), .clr(eoi_media), .q(status[IDX_MEDIA])
  );

  irq_latch u_snd (
    .clk(clk), .rst(rst), .set(snd_req), .clr(eoi_snd), .q(status[IDX_SND])
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic tset;
    irq_tmr_sync u_sync (
      .clk(clk), .rst(rst), .uf(tmr_uf[i]), .fall(tmr_fall[i]), .set_ev(tset)
    );
    irq_latch u_lat (
      .clk(clk), .rst(rst), .set(tset), .clr(eoi_tmr[i]), .q(status[IDX_TMR0+i])
    );
    AST_TMR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      $rose(status[IDX_TMR0+i]) |-> $past(tmr_fall[i])); // R6
  end

  always_ff @(posedge clk) begin
    if (rst) lvl <= '0;
    else     lvl <= {ext3, ~ext2_n, ~ext1_n};
  end
  assign status[IDX_EXT3:IDX_EXT1] = lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      irq  <= 1'b0;
      fiq  <= 1'b0;
    end else begin
      if (mask_we) mask <= mask_in;
      irq <= |(status[NSRC-1:IDX_SND] & mask[NSRC-1:IDX_SND]);
      fiq <= status[IDX_MEDIA] & mask[IDX_MEDIA];
    end
  end

  AST_FIQ_FROM_MEDIA: assert property (@(posedge clk) disable iff (rst)
    fiq |-> $past(status[IDX_MEDIA])); // R3
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|status[NSRC-1:IDX_SND])); // R10
  AST_EXT1_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !ext1_n |=> status[IDX_EXT1]); // R4
  AST_EXT3_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !ext3 |=> !status[IDX_EXT3]); // R5
endmodule

// File: tb/tb_irq_cond_top.sv
module tb_irq_cond_top;
  localparam int N_TMR = 2;
  localparam int NSRC  = 5 + N_TMR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_16k = 0, media_pin = 0, snd_req = 0;
  logic ext1_n = 1, ext2_n = 1, ext3 = 0;
  logic [N_TMR-1:0] tmr_uf = '0, tmr_fall = '0, eoi_tmr = '0;
  logic eoi_media = 0, eoi_snd = 0, mask_we = 0;
  logic [NSRC-1:0] mask_in = '0;
  logic [NSRC-1:0] status;
  logic irq, fiq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_cond_top #(.DG_SAMPLES(2), .N_TMR(N_TMR)) dut (
    .clk(clk), .rst(rst), .tick_16k(tick_16k), .media_pin(media_pin),
    .snd_req(snd_req), .ext1_n(ext1_n), .ext2_n(ext2_n), .ext3(ext3),
    .tmr_uf(tmr_uf), .tmr_fall(tmr_fall), .eoi_media(eoi_media),
    .eoi_snd(eoi_snd), .eoi_tmr(eoi_tmr), .mask_we(mask_we),
    .mask_in(mask_in), .status(status), .irq(irq), .fiq(fiq)
  );

  // {ext1_n, ext2_n, ext3, mask[6:0], exp status[4:2], exp irq}
  localparam int NV = 7;
  localparam logic [13:0] VEC [NV] = '{
    {3'b110, 7'h7F, 3'b000, 1'b0},
    {3'b010, 7'h7F, 3'b001, 1'b1},
    {3'b010, 7'h00, 3'b001, 1'b0},
    {3'b101, 7'h10, 3'b110, 1'b1},
    {3'b100, 7'h10, 3'b010, 1'b0},
    {3'b111, 7'h08, 3'b100, 1'b0},
    {3'b111, 7'h01, 3'b100, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic tick_pulse();
    tick_16k = 1; cyc(1); tick_16k = 0; cyc(1);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R11 status", status, 0);
    chk("R11 irq", irq, 0);
    chk("R11 fiq", fiq, 0);

    // table: level sources and mask (R4 R5 R10)
    for (int v = 0; v < NV; v++) begin
      {ext1_n, ext2_n, ext3} = VEC[v][13:11];
      mask_in = VEC[v][10:4];
      mask_we = 1;
      cyc(1);
      mask_we = 0;
      cyc(1);
      chk("R4 R5 level status", status[4:2], VEC[v][3:1]);
      chk("R10 irq", irq, VEC[v][0]);
    end
    ext1_n = 1; ext2_n = 1; ext3 = 0;
    mask_in = '1; mask_we = 1; cyc(1); mask_we = 0; cyc(2);
    chk("R4 R5 idle", status[4:2], 0);

    // R1: one high sample only
    media_pin = 1; tick_pulse();
    media_pin = 0; tick_pulse();
    cyc(3);
    chk("R1 single sample", status[0], 0);
    chk("R1 fiq", fiq, 0);

    // R2 R3: clean assertion
    media_pin = 1; tick_pulse(); tick_pulse();
    cyc(2);
    chk("R2 media latched", status[0], 1);
    chk("R3 fiq", fiq, 1);
    chk("R3 irq free of media", irq, 0);
    eoi_media = 1; cyc(1); eoi_media = 0;
    chk("R2 eoi clears", status[0], 0);
    tick_pulse(); tick_pulse(); cyc(1);
    chk("R2 no retrigger while high", status[0], 0);
    chk("R3 fiq drops", fiq, 0);
    media_pin = 0; tick_pulse(); tick_pulse();

    // R8 sound
    snd_req = 1; cyc(1); snd_req = 0;
    chk("R8 sound set", status[1], 1);
    cyc(1);
    chk("R10 irq from sound", irq, 1);
    eoi_snd = 1; cyc(1); eoi_snd = 0;
    chk("R8 sound clear", status[1], 0);
    // R9 collision
    snd_req = 1; eoi_snd = 1; cyc(1); snd_req = 0; eoi_snd = 0;
    chk("R9 set wins over eoi", status[1], 1);
    eoi_snd = 1; snd_req = 1; cyc(1); eoi_snd = 0; snd_req = 0;
    chk("R9 set wins while set", status[1], 1);
    eoi_snd = 1; cyc(1); eoi_snd = 0;
    cyc(1);
    chk("R8 cleared, irq low", irq, 0);

    // R6 R7 timers
    tmr_fall[1] = 1; cyc(1); tmr_fall[1] = 0; cyc(1);
    chk("R6 fall without underflow", status[6], 0);
    tmr_uf[0] = 1; cyc(1); tmr_uf[0] = 0; cyc(2);
    chk("R6 underflow alone", status[5], 0);
    tmr_fall[0] = 1; cyc(1); tmr_fall[0] = 0;
    chk("R6 timer0 set on fall", status[5], 1);
    cyc(1);
    chk("R6 irq from timer", irq, 1);
    eoi_tmr[0] = 1; cyc(1); eoi_tmr[0] = 0;
    chk("R7 timer0 eoi", status[5], 0);
    tmr_fall[0] = 1; cyc(1); tmr_fall[0] = 0;
    chk("R6 pending consumed", status[5], 0);
    tmr_uf[1] = 1; cyc(1); tmr_uf[1] = 0;
    tmr_fall[1] = 1; eoi_tmr[1] = 1; cyc(1); tmr_fall[1] = 0; eoi_tmr[1] = 0;
    chk("R9 timer1 set beats eoi", status[6], 1);
    eoi_tmr[1] = 1; cyc(1); eoi_tmr[1] = 0;
    chk("R7 timer1 eoi", status[6], 0);

    // R11 reset mid-run
    ext3 = 1; snd_req = 1; cyc(2); snd_req = 0;
    rst = 1; cyc(1); ext3 = 0; cyc(1); rst = 0;
    chk("R11 status after reset", status, 0);
    cyc(1);
    chk("R11 irq after reset", irq, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule